// File: doc/BRIEF.md
# Access Guard with Bus-Error Status Capture

This block sits beside the CPU's memory path and judges every access in the cycle the access is presented. It looks at the address, the direction, the access size, the processor privilege, and the page-map entry for the page being addressed. The rules are applied in a fixed order. If a rule is broken, the block stops the write from reaching memory and puts all-ones on the read data. In the same cycle it records what went wrong in three status registers: a general status word, a size/high-address word, and a low-address word. On the next cycle it can raise a bus-error pulse.

The status registers can always be read on their output ports. A clear strobe sets all three back to their idle value of 0xFFFF. Two control inputs change the response. With the error-enable input low, the bus-error pulse is held off, but diagnostics are still recorded. With the parity-interrupt-enable input high, one extra bit is set in the general status code. Address translation and the CPU's exception handling are done elsewhere.

Top module: `access_guard`

## Requirements
- R1: An access below 0x400000 (the RAM region) to a page whose map-entry state field (entry bits 14:13) is 0 is a page fault, in supervisor mode as well as user mode. The general status becomes 0x8BFF for a write or 0xCBFF for a read.
- R2: If the page-present check passes and the supervisor input is high, the access is allowed, whatever its address or the page's write-enable bit.
- R3: A user access at or above 0x400000 is an illegal-region fault. The general status becomes 0x9AFF for a write or 0xDAFF for a read.
- R4: A user access in the RAM region with address bits 22:19 all zero is a kernel-space fault. It raises a bus error and leaves the general status unchanged.
- R5: A user write to a present page whose write-enable bit (entry bit 15) is clear is a write-protect fault. The general status is unchanged. A user read of the same page is allowed.
- R6: When the parity-interrupt-enable input is high, bit 0x0400 is set in any general status code loaded by R1 or R3.
- R7: On every fault, bus status 0 is loaded with a lane code ORed with address bits 23:16 in its low byte. Size encoding is 0 = byte, 1 = word, 2 = long. The lane code is 0x7C00 for a word or long access, 0x7E00 for a byte access at an odd address, and 0x7D00 for a byte access at an even address.
- R8: On every fault, bus status 1 is loaded with address bits 15:0.
- R9: The bus-error output goes high for exactly one cycle, the cycle after a faulting access, and only if error-enable was high with that access. The status registers are loaded whether or not error-enable is high.
- R10: After reset, and after a clear strobe, all three status registers read 0xFFFF. If a clear and a fault arrive in the same cycle, the registers the fault writes take the fault values and the others take 0xFFFF.
- R11: A faulting write leaves the memory write-enable output low, and a faulting read returns all-ones data. An allowed access passes the write enable and the memory read data through unchanged.
- R12: The page-present check comes before every privilege and region check. A user access to a non-present page in kernel space reports the page-fault code, not the kernel-space result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_addr_i | input | 24 | Access address before translation |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_size_i | input | 2 | 0 byte, 1 word, 2 long |
| super_i | input | 1 | Processor in supervisor mode |
| map_entry_i | input | 16 | Page-map entry of the addressed page |
| err_en_i | input | 1 | Allow the bus-error output |
| par_int_en_i | input | 1 | Parity interrupts enabled |
| clr_stat_i | input | 1 | Clear strobe for the status registers |
| mem_rd_data_i | input | 32 | Read data from memory |
| mem_we_o | output | 1 | Gated memory write enable |
| rd_data_o | output | 32 | Read data returned to the CPU |
| bus_err_o | output | 1 | Bus-error pulse |
| gen_stat_o | output | 16 | General status register |
| bus_stat0_o | output | 16 | Bus status 0: lane code and address 23:16 |
| bus_stat1_o | output | 16 | Bus status 1: address 15:0 |

## Verification
The bench targets the ordering corners.

- A supervisor access to a missing page must fault. A design that put the supervisor bypass first would let it through silently.
- A user access to a missing kernel page must report the page-fault code. A reordered chain would report a kernel fault and leave the general status untouched.
- Kernel-space and write-protect faults must leave the general status unchanged. A design that wrote a code for every fault would overwrite earlier diagnostics.
- Byte accesses at odd and even addresses must produce different lane codes. Swapped codes would point the handler at the wrong byte.
- A faulting access with error-enable low must still load the registers but give no pulse.
- When a clear and a fault coincide, the fault must win. Giving the clear priority would lose the diagnostics.

// File: rtl/access_guard_pkg.sv
package access_guard_pkg;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_PAGE   = 3'd1,
    FLT_REGION = 3'd2,
    FLT_KERNEL = 3'd3,
    FLT_WPROT  = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } acc_size_e;

  localparam int unsigned STAT_W      = 16;
  localparam logic [15:0] STAT_IDLE   = 16'hFFFF;
  localparam logic [15:0] GS_PAGE_WR  = 16'h8BFF;
  localparam logic [15:0] GS_PAGE_RD  = 16'hCBFF;
  localparam logic [15:0] GS_REG_WR   = 16'h9AFF;
  localparam logic [15:0] GS_REG_RD   = 16'hDAFF;
  localparam logic [15:0] GS_PIE_BIT  = 16'h0400;
  localparam logic [15:0] LANE_WIDE   = 16'h7C00;
  localparam logic [15:0] LANE_ODD    = 16'h7E00;
  localparam logic [15:0] LANE_EVEN   = 16'h7D00;

  // Map entry layout: bit 15 write enable, bits 14:13 page state.
  localparam int unsigned ENT_WE_BIT  = 15;
  localparam int unsigned ENT_ST_HI   = 14;
  localparam int unsigned ENT_ST_LO   = 13;

  function automatic logic [15:0] gen_code(fault_e kind, logic wr, logic pie);
    logic [15:0] c;
    case (kind)
      FLT_PAGE:   c = wr ? GS_PAGE_WR : GS_PAGE_RD;
      FLT_REGION: c = wr ? GS_REG_WR  : GS_REG_RD;
      default:    c = STAT_IDLE;
    endcase
    return pie ? (c | GS_PIE_BIT) : c;
  endfunction

  function automatic logic [15:0] lane_code(acc_size_e sz, logic a0);
    if (sz == SZ_BYTE) return a0 ? LANE_ODD : LANE_EVEN;
    return LANE_WIDE;
  endfunction

endpackage

// File: rtl/access_guard_rules.sv
module access_guard_rules
  import access_guard_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned RAM_LIMIT = 32'h0040_0000,
  parameter int unsigned KERN_LO   = 19,
  parameter int unsigned KERN_HI   = 22
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic              super_i,
  input  logic [15:0]       entry_i,
  output fault_e            kind_o
);

  localparam int unsigned KERN_W = KERN_HI - KERN_LO + 1;

  logic in_ram, absent, kern_zone, wr_locked;

  assign in_ram    = ({{(32-ADDR_W){1'b0}}, addr_i} < RAM_LIMIT);
  assign absent    = (entry_i[ENT_ST_HI:ENT_ST_LO] == 2'b00);
  assign kern_zone = (addr_i[KERN_HI:KERN_LO] == {KERN_W{1'b0}});
  assign wr_locked = write_i && !entry_i[ENT_WE_BIT];

  // Ordered chain: presence, supervisor bypass, region, kernel, write-protect.
  always_comb begin
    if (in_ram && absent)  kind_o = FLT_PAGE;
    else if (super_i)      kind_o = FLT_NONE;
    else if (!in_ram)      kind_o = FLT_REGION;
    else if (kern_zone)    kind_o = FLT_KERNEL;
    else if (wr_locked)    kind_o = FLT_WPROT;
    else                   kind_o = FLT_NONE;
  end

  always_comb begin
    // R2
    if (super_i === 1'b1 && !(in_ram && absent))
      sup_bypass_chk: assert (kind_o == FLT_NONE);
  end

endmodule

// File: rtl/access_guard_status.sv
module access_guard_status
  import access_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_stb_i,
  input  fault_e            kind_i,
  input  logic              write_i,
  input  acc_size_e         size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pie_i,
  input  logic              clr_i,
  output logic [15:0]       gen_stat_o,
  output logic [15:0]       bus_stat0_o,
  output logic [15:0]       bus_stat1_o
);

  localparam int unsigned HI_W = ADDR_W - 16;

  logic [15:0] gen_q, bs0_q, bs1_q;
  logic        gen_load;
  logic [7:0]  hi_byte;

  assign gen_load = fault_stb_i && (kind_i == FLT_PAGE || kind_i == FLT_REGION);
  assign hi_byte  = 8'(addr_i[ADDR_W-1:16]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q <= STAT_IDLE;
      bs0_q <= STAT_IDLE;
      bs1_q <= STAT_IDLE;
    end else begin
      if (clr_i) begin
        gen_q <= STAT_IDLE;
        bs0_q <= STAT_IDLE;
        bs1_q <= STAT_IDLE;
      end
      // Fault capture overrides a coincident clear.
      if (fault_stb_i) begin
        bs0_q <= lane_code(size_i, addr_i[0]) | {8'h00, hi_byte};
        bs1_q <= addr_i[15:0];
      end
      if (gen_load) gen_q <= gen_code(kind_i, write_i, pie_i);
    end
  end

  assign gen_stat_o  = gen_q;
  assign bus_stat0_o = bs0_q;
  assign bus_stat1_o = bs1_q;

  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R8
  lo_addr_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(fault_stb_i) |-> bus_stat1_o == $past(addr_i[15:0]));

  // R4
  gen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(fault_stb_i && !clr_i &&
                     (kind_i == FLT_KERNEL || kind_i == FLT_WPROT))
    |-> $stable(gen_stat_o));

  // R10
  clear_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(clr_i && !fault_stb_i)
    |-> (gen_stat_o == STAT_IDLE && bus_stat0_o == STAT_IDLE && bus_stat1_o == STAT_IDLE));

  // R7
  lane_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(fault_stb_i) |-> bus_stat0_o[15:12] == 4'h7);

endmodule

// File: rtl/access_guard.sv
module access_guard
  import access_guard_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned RAM_LIMIT = 32'h0040_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic [1:0]        acc_size_i,
  input  logic              super_i,
  input  logic [15:0]       map_entry_i,
  input  logic              err_en_i,
  input  logic              par_int_en_i,
  input  logic              clr_stat_i,
  input  logic [DATA_W-1:0] mem_rd_data_i,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              bus_err_o,
  output logic [15:0]       gen_stat_o,
  output logic [15:0]       bus_stat0_o,
  output logic [15:0]       bus_stat1_o
);

  fault_e    kind;
  logic      faulted, fault_stb;
  logic      berr_q;
  acc_size_e size;

  assign size = acc_size_e'(acc_size_i);

  access_guard_rules #(
    .ADDR_W   (ADDR_W),
    .RAM_LIMIT(RAM_LIMIT)
  ) u_rules (
    .addr_i (acc_addr_i),
    .write_i(acc_write_i),
    .super_i(super_i),
    .entry_i(map_entry_i),
    .kind_o (kind)
  );

  assign faulted   = (kind != FLT_NONE);
  assign fault_stb = acc_valid_i && faulted;

  access_guard_status #(
    .ADDR_W(ADDR_W)
  ) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fault_stb_i(fault_stb),
    .kind_i     (kind),
    .write_i    (acc_write_i),
    .size_i     (size),
    .addr_i     (acc_addr_i),
    .pie_i      (par_int_en_i),
    .clr_i      (clr_stat_i),
    .gen_stat_o (gen_stat_o),
    .bus_stat0_o(bus_stat0_o),
    .bus_stat1_o(bus_stat1_o)
  );

  assign mem_we_o  = acc_valid_i && acc_write_i && !faulted;
  assign rd_data_o = fault_stb ? {DATA_W{1'b1}} : mem_rd_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) berr_q <= 1'b0;
    else         berr_q <= fault_stb && err_en_i;
  end
  assign bus_err_o = berr_q;

  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R9
  berr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> armed_q && $past(acc_valid_i && err_en_i && faulted));

  // R9
  berr_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(!err_en_i) |-> !bus_err_o);

  // R11
  no_bad_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> acc_write_i && !faulted);

  // R11
  ones_on_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_stb |-> rd_data_o == {DATA_W{1'b1}});

endmodule

// File: tb/access_guard_tb_top.sv
module access_guard_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [23:0] addr = '0;
  logic        wr = 1'b0;
  logic [1:0]  size = 2'd1;
  logic        sup = 1'b0;
  logic [15:0] entry = '0;
  logic        ee = 1'b0;
  logic        pie = 1'b0;
  logic        clr = 1'b0;
  logic [31:0] mrd = '0;
  logic        we_o;
  logic [31:0] rd_o;
  logic        berr_o;
  logic [15:0] gs_o, b0_o, b1_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] e_gs = 16'hFFFF, e_b0 = 16'hFFFF, e_b1 = 16'hFFFF;

  always #5 clk = ~clk;

  access_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_addr_i(addr),
    .acc_write_i(wr), .acc_size_i(size), .super_i(sup), .map_entry_i(entry),
    .err_en_i(ee), .par_int_en_i(pie), .clr_stat_i(clr), .mem_rd_data_i(mrd),
    .mem_we_o(we_o), .rd_data_o(rd_o), .bus_err_o(berr_o),
    .gen_stat_o(gs_o), .bus_stat0_o(b0_o), .bus_stat1_o(b1_o)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // 0 none, 1 page, 2 region, 3 kernel, 4 write-protect
  function automatic int model_kind(logic [23:0] a, logic w, logic s, logic [15:0] e);
    if (a < 24'h400000 && e[14:13] == 2'b00) return 1;
    if (s) return 0;
    if (a >= 24'h400000) return 2;
    if (a[22:19] == 4'h0) return 3;
    if (w && !e[15]) return 4;
    return 0;
  endfunction

  function automatic logic [15:0] model_gs(int k, logic w, logic p);
    logic [15:0] c;
    c = (k == 1) ? (w ? 16'h8BFF : 16'hCBFF) : (w ? 16'h9AFF : 16'hDAFF);
    return p ? (c | 16'h0400) : c;
  endfunction

  function automatic logic [15:0] model_b0(logic [1:0] sz, logic [23:0] a);
    logic [15:0] l;
    l = (sz == 2'd0) ? (a[0] ? 16'h7E00 : 16'h7D00) : 16'h7C00;
    return l | {8'h00, a[23:16]};
  endfunction

  task automatic check_regs(string req);
    chk(req, "gen_stat", {16'h0, gs_o}, {16'h0, e_gs});
    chk(req, "bus_stat0", {16'h0, b0_o}, {16'h0, e_b0});
    chk(req, "bus_stat1", {16'h0, b1_o}, {16'h0, e_b1});
  endtask

  task automatic access(string req, logic [23:0] a, logic w, logic [1:0] sz,
                        logic s, logic [15:0] e, logic en, logic p, logic c);
    int k;
    @(negedge clk);
    valid = 1'b1; addr = a; wr = w; size = sz; sup = s; entry = e;
    ee = en; pie = p; clr = c; mrd = {8'h5A, a};
    #1;
    k = model_kind(a, w, s, e);
    chk(req, "fault class (R11 we)", {31'h0, we_o}, {31'h0, (w && k == 0)});
    chk(req, "read data (R11)", rd_o, (k != 0) ? 32'hFFFF_FFFF : {8'h5A, a});
    if (c) begin e_gs = 16'hFFFF; e_b0 = 16'hFFFF; e_b1 = 16'hFFFF; end
    if (k != 0) begin
      if (k <= 2) e_gs = model_gs(k, w, p);
      e_b0 = model_b0(sz, a);
      e_b1 = a[15:0];
    end
    @(negedge clk);
    valid = 1'b0; clr = 1'b0;
    chk(req, "bus_err pulse (R9)", {31'h0, berr_o}, {31'h0, (k != 0 && en)});
    check_regs(req);
    @(negedge clk);
    chk("R9", "bus_err single cycle", {31'h0, berr_o}, 32'h0);
  endtask

  task automatic t_reset;
    chk("R10", "reset bus_err", {31'h0, berr_o}, 32'h0);
    check_regs("R10");
  endtask

  task automatic t_page_fault;
    access("R1", 24'h012345, 1'b0, 2'd1, 1'b1, 16'h8000, 1'b1, 1'b0, 1'b0);
    access("R1", 24'h1A0000, 1'b1, 2'd2, 1'b0, 16'h9FFF, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_super;
    access("R2", 24'h001000, 1'b1, 2'd1, 1'b1, 16'h2000, 1'b1, 1'b0, 1'b0);
    access("R2", 24'h500000, 1'b0, 2'd1, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_region;
    access("R3", 24'h6F0002, 1'b0, 2'd1, 1'b0, 16'hE000, 1'b1, 1'b0, 1'b0);
    access("R3", 24'hE40000, 1'b1, 2'd2, 1'b0, 16'hE000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_kernel;
    access("R4", 24'h040010, 1'b0, 2'd1, 1'b0, 16'hA000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_wprot;
    access("R5", 24'h300000, 1'b1, 2'd1, 1'b0, 16'h2000, 1'b1, 1'b0, 1'b0);
    access("R5", 24'h300004, 1'b0, 2'd1, 1'b0, 16'h2000, 1'b1, 1'b0, 1'b0);
    access("R5", 24'h300008, 1'b1, 2'd1, 1'b0, 16'hA000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_parity;
    access("R6", 24'h200000, 1'b0, 2'd1, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0);
    access("R6", 24'h800000, 1'b1, 2'd1, 1'b0, 16'hE000, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_lanes;
    access("R7", 24'hC3ABCD, 1'b0, 2'd0, 1'b0, 16'hE000, 1'b1, 1'b0, 1'b0);
    access("R7", 24'hC3ABCC, 1'b0, 2'd0, 1'b0, 16'hE000, 1'b1, 1'b0, 1'b0);
    access("R8", 24'h7F1234, 1'b1, 2'd1, 1'b0, 16'hE000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_err_masked;
    access("R9", 24'h450006, 1'b0, 2'd2, 1'b0, 16'hE000, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_clear;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    e_gs = 16'hFFFF; e_b0 = 16'hFFFF; e_b1 = 16'hFFFF;
    check_regs("R10");
    access("R10", 24'h9A0101, 1'b1, 2'd0, 1'b0, 16'hE000, 1'b1, 1'b0, 1'b1);
    access("R10", 24'h040000, 1'b0, 2'd1, 1'b0, 16'hE000, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_order;
    access("R12", 24'h010000, 1'b1, 2'd1, 1'b0, 16'h8000, 1'b1, 1'b0, 1'b0);
    access("R12", 24'h020000, 1'b0, 2'd1, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_pass;
    access("R11", 24'h3F0000, 1'b1, 2'd2, 1'b0, 16'hC000, 1'b1, 1'b0, 1'b0);
    access("R11", 24'h3F0010, 1'b0, 2'd1, 1'b0, 16'h4000, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_page_fault();
    t_super();
    t_region();
    t_kernel();
    t_wprot();
    t_parity();
    t_lanes();
    t_err_masked();
    t_clear();
    t_order();
    t_pass();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule